// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit execution unit for packed integer data. Each operation splits its two 64-bit operands into eight 8-bit, four 16-bit or two 32-bit lanes and applies the same operation to every lane in parallel. It provides lane-wise add and subtract with a choice of overflow behaviour, and left, logical-right and arithmetic-right shifts by a common count. It also provides full-width bitwise logic, and a lane-wise multiply that keeps the low half of each product, with an optional accumulate into a third operand.

A scheduler presents the operands, lane size, opcode, saturation mode and shift count together with a valid strobe. The result is captured in an output register and appears one clock later with its own valid flag. No lane ever sees a carry, borrow, shifted bit or sign from its neighbour.

Top module: `simd_alu`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (subtract, A minus B) with sat_mode 0 or 3 wrap modulo the lane width. The lane size code is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit lanes, and code 3 acts as 32-bit. No carry or borrow passes between lanes.
- R2: With sat_mode 1, an add or subtract that leaves the signed range of a lane clamps to that lane's most positive or most negative value.
- R3: With sat_mode 2, an unsigned add that overflows a lane gives all ones in that lane, and an unsigned subtract that underflows gives zero.
- R4: Opcode 2 shifts each lane left, opcode 3 shifts it right with zero fill, and opcode 4 shifts it right with sign fill. All lanes shift by the same count, and no bit moves between lanes.
- R5: A shift count at or above the lane width gives zero for opcodes 2 and 3 and a copy of each lane's sign bit in every position for opcode 4.
- R6: Opcodes 5 (A AND B), 6 (A OR B), 7 (A XOR B) and 8 ((NOT A) AND B) act on all 64 bits, and the lane size has no effect on them.
- R7: Opcode 9 gives, in each lane, the low lane-width bits of the product of the A and B lanes.
- R8: Opcode 10 adds the low-half lane product to the matching lane of the accumulator operand, wrapping modulo the lane width.
- R9: out_valid equals in_valid from the previous clock, and the result of an accepted operation appears exactly one cycle after it is presented.
- R10: Synchronous reset clears result and out_valid. While in_valid is low, result keeps its last value.
- R11: Opcodes 11 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented this cycle |
| lane_sz | input | 2 | Lane size code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| opcode | input | 4 | Operation select |
| sat_mode | input | 2 | Add/sub overflow mode: 0/3 wrap, 1 signed clamp, 2 unsigned clamp |
| shamt | input | 6 | Shift count applied to every lane |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| src_acc | input | 64 | Accumulator operand for multiply-accumulate |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered packed result |

## Verification
The hard case is a lane boundary where one lane saturates or wraps while its neighbour does something else in the same operation. One vector drives a signed add in which the low byte lane underflows toward the negative limit while the next lane overflows toward the positive limit. The vector passes only if each lane holds its own clamp value and neither has taken a carry from the other. A second collision is between a new valid operation and the hold rule: the bench streams operations back to back, then drops the strobe while changing the operands. It checks that the register keeps the last result and that out_valid falls in the cycle after the strobe does.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W    = 64;
    localparam int SHAMT_W   = 6;
    localparam int NUM_SIZES = 3;
    localparam int MIN_LANE  = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORDX = 2'd3
    } lane_sz_e;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLL  = 4'd2,
        OP_SRL  = 4'd3,
        OP_SRA  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_ANDN = 4'd8,
        OP_MUL  = 4'd9,
        OP_MAC  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        SAT_WRAP   = 2'd0,
        SAT_SIGNED = 2'd1,
        SAT_UNSIG  = 2'd2,
        SAT_WRAPX  = 2'd3
    } sat_e;

    typedef enum logic [1:0] {
        SH_LEFT   = 2'd0,
        SH_RLOG   = 2'd1,
        SH_RARITH = 2'd2
    } shk_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } result_t;

    function automatic logic [1:0] size_index(lane_sz_e s);
        case (s)
            SZ_BYTE: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic shk_e shift_kind(op_e op);
        case (op)
            OP_SLL:  return SH_LEFT;
            OP_SRL:  return SH_RLOG;
            default: return SH_RARITH;
        endcase
    endfunction

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  sat_e              mode,
    output logic [DATA_W-1:0] y
);
    localparam int NLANES = DATA_W / LANE_W;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [LANE_W-1:0] la, lb, lr;
        logic [LANE_W:0]   s_sum, u_sum;

        assign la = a[l*LANE_W +: LANE_W];
        assign lb = b[l*LANE_W +: LANE_W];

        always_comb begin
            if (sub) begin
                s_sum = {la[LANE_W-1], la} - {lb[LANE_W-1], lb};
                u_sum = {1'b0, la} - {1'b0, lb};
            end else begin
                s_sum = {la[LANE_W-1], la} + {lb[LANE_W-1], lb};
                u_sum = {1'b0, la} + {1'b0, lb};
            end
            lr = u_sum[LANE_W-1:0];
            case (mode)
                SAT_SIGNED: begin
                    if (s_sum[LANE_W] != s_sum[LANE_W-1])
                        lr = s_sum[LANE_W] ? {1'b1, {(LANE_W-1){1'b0}}}
                                           : {1'b0, {(LANE_W-1){1'b1}}};
                end
                SAT_UNSIG: begin
                    if (u_sum[LANE_W])
                        lr = sub ? '0 : '1;
                end
                default: ;
            endcase
        end

        assign y[l*LANE_W +: LANE_W] = lr;

        // unsigned clamp never moves a lane the wrong way (R3)
        always_comb begin
            if (mode == SAT_UNSIG) begin
                if (!sub) begin
                    assert_usat_add_floor_R3: assert (lr >= la && lr >= lb);
                end else begin
                    assert_usat_sub_ceiling_R3: assert (lr <= la);
                end
            end
        end

        // signed clamp keeps the sign of the first operand on overflow (R2)
        always_comb begin
            if (mode == SAT_SIGNED && !sub && la[LANE_W-1] == lb[LANE_W-1]) begin
                assert_ssat_sign_R2: assert (lr[LANE_W-1] == la[LANE_W-1]);
            end
        end
    end

endmodule

// File: rtl/simd_shift.sv
module simd_shift
    import simd_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int LANE_W  = 8,
    parameter int SHAMT_W = 6
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [SHAMT_W-1:0] shamt,
    input  shk_e               kind,
    output logic [DATA_W-1:0]  y
);
    localparam int NLANES = DATA_W / LANE_W;
    localparam int AMT_W  = $clog2(LANE_W);

    logic             big;
    logic [AMT_W-1:0] amt;

    assign big = (32'(shamt) >= LANE_W);
    assign amt = shamt[AMT_W-1:0];

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [LANE_W-1:0] la, lr;

        assign la = a[l*LANE_W +: LANE_W];

        always_comb begin
            case (kind)
                SH_LEFT:  lr = big ? '0 : (la << amt);
                SH_RLOG:  lr = big ? '0 : (la >> amt);
                default:  lr = big ? {LANE_W{la[LANE_W-1]}}
                                   : LANE_W'($signed(la) >>> amt);
            endcase
        end

        assign y[l*LANE_W +: LANE_W] = lr;

        always_comb begin
            if (kind == SH_RLOG) begin
                assert_srl_shrinks_R4: assert (lr <= la);
            end
            if (kind == SH_LEFT && shamt != '0) begin
                assert_sll_zero_lsb_R4: assert (lr[0] == 1'b0);
            end
            if (kind == SH_RARITH) begin
                assert_sra_sign_kept_R5: assert (lr[LANE_W-1] == la[LANE_W-1]);
            end
        end
    end

endmodule

// File: rtl/simd_mul.sv
module simd_mul #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] acc,
    input  logic              accumulate,
    output logic [DATA_W-1:0] y
);
    localparam int NLANES = DATA_W / LANE_W;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [LANE_W-1:0] la, lb, lc, prod;

        assign la   = a[l*LANE_W +: LANE_W];
        assign lb   = b[l*LANE_W +: LANE_W];
        assign lc   = acc[l*LANE_W +: LANE_W];
        assign prod = la * lb;

        assign y[l*LANE_W +: LANE_W] = accumulate ? (prod + lc) : prod;
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DW = 64,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    lane_sz,
    input  logic [3:0]    opcode,
    input  logic [1:0]    sat_mode,
    input  logic [SW-1:0] shamt,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] src_acc,
    output logic          out_valid,
    output logic [DW-1:0] result
);
    op_e        op;
    logic [1:0] sidx;
    logic       is_sub, is_mac;
    shk_e       skind;
    sat_e       smode;

    assign op     = op_e'(opcode);
    assign sidx   = size_index(lane_sz_e'(lane_sz));
    assign is_sub = (op == OP_SUB);
    assign is_mac = (op == OP_MAC);
    assign skind  = shift_kind(op);
    assign smode  = sat_e'(sat_mode);

    logic [DW-1:0] as_res [NUM_SIZES];
    logic [DW-1:0] sh_res [NUM_SIZES];
    logic [DW-1:0] mu_res [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int LW = MIN_LANE << g;

        simd_addsub #(.DATA_W(DW), .LANE_W(LW)) u_addsub (
            .a    (src_a),
            .b    (src_b),
            .sub  (is_sub),
            .mode (smode),
            .y    (as_res[g])
        );

        simd_shift #(.DATA_W(DW), .LANE_W(LW), .SHAMT_W(SW)) u_shift (
            .a     (src_a),
            .shamt (shamt),
            .kind  (skind),
            .y     (sh_res[g])
        );

        simd_mul #(.DATA_W(DW), .LANE_W(LW)) u_mul (
            .a          (src_a),
            .b          (src_b),
            .acc        (src_acc),
            .accumulate (is_mac),
            .y          (mu_res[g])
        );
    end

    logic [DW-1:0] nxt;

    always_comb begin
        case (op)
            OP_ADD, OP_SUB:         nxt = as_res[sidx];
            OP_SLL, OP_SRL, OP_SRA: nxt = sh_res[sidx];
            OP_AND:                 nxt = src_a & src_b;
            OP_OR:                  nxt = src_a | src_b;
            OP_XOR:                 nxt = src_a ^ src_b;
            OP_ANDN:                nxt = ~src_a & src_b;
            OP_MUL, OP_MAC:         nxt = mu_res[sidx];
            default:                nxt = '0;
        endcase
    end

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } res_reg_t;

    res_reg_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) begin
                res_q.data <= nxt;
            end
        end
    end

    assign out_valid = res_q.valid;
    assign result    = res_q.data;

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    assert_xor_full_width_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 4'd7) |=> (result == ($past(src_a) ^ $past(src_b))));

    assert_unknown_op_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode > 4'd10) |=> (result == '0));

endmodule

// File: tb/simd_alu_test.sv
module simd_alu_test;
    import simd_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  lane_sz;
    logic [3:0]  opcode;
    logic [1:0]  sat_mode;
    logic [5:0]  shamt;
    logic [63:0] src_a, src_b, src_acc;
    logic        out_valid;
    logic [63:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    simd_alu uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .lane_sz  (lane_sz),
        .opcode   (opcode),
        .sat_mode (sat_mode),
        .shamt    (shamt),
        .src_a    (src_a),
        .src_b    (src_b),
        .src_acc  (src_acc),
        .out_valid(out_valid),
        .result   (result)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic [1:0]  sm;
        logic [5:0]  sh;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] c;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;

    localparam vec_t VECS [NV] = '{
        // R1 byte add wraps, no carry into lane 1
        '{4'd0, 2'd0, 2'd0, 6'd0, 64'h01FF, 64'h0101, 64'h0, 64'h0200, 8'd1},
        // R1 same operands as one 16-bit lane
        '{4'd0, 2'd1, 2'd0, 6'd0, 64'h01FF, 64'h0101, 64'h0, 64'h0300, 8'd1},
        // R1 byte subtract wraps, no borrow out of lane 0
        '{4'd1, 2'd0, 2'd0, 6'd0, 64'h0, 64'h1, 64'h0, 64'h00FF, 8'd1},
        // R1 word subtract wraps in low lane only
        '{4'd1, 2'd2, 2'd3, 6'd0, 64'h0, 64'h1, 64'h0, 64'h0000_0000_FFFF_FFFF, 8'd1},
        // R1 size code 3 acts as 32-bit
        '{4'd0, 2'd3, 2'd0, 6'd0, 64'h0000_FFFF, 64'h1, 64'h0, 64'h0001_0000, 8'd1},
        // R2 neighbouring byte lanes clamp in opposite directions
        '{4'd0, 2'd0, 2'd1, 6'd0, 64'h7F80, 64'h01FF, 64'h0, 64'h7F80, 8'd2},
        // R2 halfword subtract clamps at most negative
        '{4'd1, 2'd1, 2'd1, 6'd0, 64'h8000, 64'h0001, 64'h0, 64'h8000, 8'd2},
        // R2 word add clamps high lane, low lane unaffected
        '{4'd0, 2'd2, 2'd1, 6'd0, 64'h7FFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 64'h0,
          64'h7FFF_FFFF_0000_0002, 8'd2},
        // R3 unsigned add clamps lane 0 to all ones
        '{4'd0, 2'd0, 2'd2, 6'd0, 64'h10F0, 64'h2020, 64'h0, 64'h30FF, 8'd3},
        // R3 unsigned subtract clamps lane 0 to zero
        '{4'd1, 2'd0, 2'd2, 6'd0, 64'h1005, 64'h0506, 64'h0, 64'h0B00, 8'd3},
        // R4 byte left shift drops the lane's top bit
        '{4'd2, 2'd0, 2'd0, 6'd1, 64'h8181, 64'h0, 64'h0, 64'h0202, 8'd4},
        // R4 halfword logical right shift
        '{4'd3, 2'd1, 2'd0, 6'd4, 64'h8001_0000_0000_F0F0, 64'h0, 64'h0,
          64'h0800_0000_0000_0F0F, 8'd4},
        // R4 byte arithmetic right shift, per-lane sign
        '{4'd4, 2'd0, 2'd0, 6'd2, 64'h8040, 64'h0, 64'h0, 64'hE010, 8'd4},
        // R4 word logical right shift by width minus one
        '{4'd3, 2'd2, 2'd0, 6'd31, 64'h8000_0000_8000_0000, 64'h0, 64'h0,
          64'h0000_0001_0000_0001, 8'd4},
        // R5 arithmetic shift past word width fills with sign
        '{4'd4, 2'd2, 2'd0, 6'd40, 64'h8000_0000_7FFF_FFFF, 64'h0, 64'h0,
          64'hFFFF_FFFF_0000_0000, 8'd5},
        // R5 logical right by exactly byte width
        '{4'd3, 2'd0, 2'd0, 6'd8, 64'hFFFF, 64'h0, 64'h0, 64'h0, 8'd5},
        // R5 left by exactly halfword width
        '{4'd2, 2'd1, 2'd0, 6'd16, 64'h1234, 64'h0, 64'h0, 64'h0, 8'd5},
        // R6 AND
        '{4'd5, 2'd0, 2'd0, 6'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0,
          64'hF000_F000_F000_F000, 8'd6},
        // R6 OR
        '{4'd6, 2'd1, 2'd0, 6'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0,
          64'hFFF0_FFF0_FFF0_FFF0, 8'd6},
        // R6 XOR
        '{4'd7, 2'd2, 2'd0, 6'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0,
          64'h0FF0_0FF0_0FF0_0FF0, 8'd6},
        // R6 AND-NOT
        '{4'd8, 2'd0, 2'd0, 6'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0,
          64'h0F00_0F00_0F00_0F00, 8'd6},
        // R7 byte multiply, lane 1 product truncates to zero
        '{4'd9, 2'd0, 2'd0, 6'd0, 64'h1003, 64'h1005, 64'h0, 64'h000F, 8'd7},
        // R7 halfword multiply keeps low half
        '{4'd9, 2'd1, 2'd0, 6'd0, 64'hFFFF, 64'h0002, 64'h0, 64'hFFFE, 8'd7},
        // R7 word multiply
        '{4'd9, 2'd2, 2'd0, 6'd0, 64'h0001_0000_0000_0003, 64'h0001_0000_0000_0007, 64'h0,
          64'h15, 8'd7},
        // R8 byte multiply-accumulate wraps per lane
        '{4'd10, 2'd0, 2'd0, 6'd0, 64'h0203, 64'h0204, 64'h01FF, 64'h050B, 8'd8},
        // R8 halfword product overflows, then accumulate
        '{4'd10, 2'd1, 2'd0, 6'd0, 64'h0100, 64'h0100, 64'h0001, 64'h0001, 8'd8},
        // R11 undefined opcode
        '{4'd15, 2'd0, 2'd0, 6'd0, 64'hFFFF, 64'hFFFF, 64'hFFFF, 64'h0, 8'd11}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v, logic vld);
        in_valid = vld;
        opcode   = v.op;
        lane_sz  = v.sz;
        sat_mode = v.sm;
        shamt    = v.sh;
        src_a    = v.a;
        src_b    = v.b;
        src_acc  = v.c;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        drive(VECS[0], 1'b1);
        repeat (3) @(negedge clk);
        // R10 reset state even with a valid operation presented
        check("R10", {63'b0, out_valid}, 64'h0);
        check("R10", result, 64'h0);

        in_valid = 1'b0;
        rst      = 1'b0;
        @(negedge clk);
        // R9 no valid presented, no valid out
        check("R9", {63'b0, out_valid}, 64'h0);

        // streamed table walk, one result per cycle
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            check("R9", {63'b0, out_valid}, 64'h1);
            check($sformatf("R%0d", VECS[i].req), result, VECS[i].exp);
        end

        // R10 hold: strobe low, operands changed
        drive(VECS[5], 1'b0);
        @(negedge clk);
        check("R9", {63'b0, out_valid}, 64'h0);
        check("R10", result, VECS[NV-1].exp);
        @(negedge clk);
        check("R10", result, VECS[NV-1].exp);

        // R9 exact latency: present one op, look one cycle later
        drive(VECS[6], 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", result, VECS[6].exp);
        @(negedge clk);
        check("R9", {63'b0, out_valid}, 64'h0);

        // R6 lane size does not change a logic op
        drive(VECS[19], 1'b1);
        lane_sz = 2'd0;
        @(negedge clk);
        check("R6", result, VECS[19].exp);

        // R10 reset during a valid operation
        drive(VECS[0], 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R10", result, 64'h0);
        check("R10", {63'b0, out_valid}, 64'h0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        summary();
    end

endmodule